// File: doc/BRIEF.md
# Eight-bit arithmetic-logic unit with a held status word

This block is the integer datapath slice of a small RISC core. Each cycle it can accept one operation on two eight-bit operands. The first operand always comes from a register. The second comes from a register or from an immediate field. The operation code selects one of thirteen functions. The incoming carry is the carry bit held in the block's own status word, so multi-byte add, subtract and compare chains need no extra wiring.

The block registers the result and the six status bits on the clock edge that accepts the operation. Each operation has its own mask of status bits it may change, and every bit outside that mask keeps its value. Compare operations change only the status word and never raise the write-back strobe. The carry-chained subtract and compare treat the zero bit as sticky: a zero result never sets it, so a chain of bytes reports zero only if every byte was zero.

The block has no state machine. It has one status register and one result register, updated together.

Top module: `alu8_status_unit`

## Requirements
- R1: While `rst_n` is low, and after its release, `res_q` is 0x00, `res_we` is 0 and `flags_q` is 0. The status bit positions are C=0, Z=1, N=2, V=3, S=4 and H=5.
- R2: Code 0 (add) gives A+B. Code 1 (add with carry) gives A+B+C. C is the carry out of bit 7, H is the carry out of bit 3, V is set when the signed sum falls outside -128..127, N is bit 7 of the result, and Z is set for a zero result.
- R3: Code 2 (subtract) gives A-B. Code 3 (subtract with carry) gives A-B-C. C is the borrow out of bit 7, H is the borrow out of bit 3, V is signed overflow of the difference, and N is bit 7 of the result.
- R4: Code 4 (compare) and code 5 (compare with carry) set the status bits exactly as codes 2 and 3 would. They leave `res_q` unchanged and keep `res_we` at 0.
- R5: After code 3 or code 5, Z is 0 if the byte result is non-zero. If the byte result is zero, Z keeps its previous value.
- R6: Codes 6 (AND), 7 (OR) and 8 (XOR) produce the bitwise result. They update Z and N, clear V, and leave C and H unchanged.
- R7: Code 9 (one's complement) gives 0xFF-A. It sets C to 1, clears V, updates Z and N, and leaves H unchanged.
- R8: Code 10 (negate) gives 0x00-A, with all six status bits set as for a subtraction of A from zero.
- R9: Code 11 (increment) gives A+1 and sets V only for A=0x7F. Code 12 (decrement) gives A-1 and sets V only for A=0x80. Both leave C and H unchanged.
- R10: After every operation, S equals N XOR V, so S=0 means signed greater-or-equal.
- R11: When `imm_sel` is 1, `imm` replaces `reg_b` as the second operand.
- R12: A cycle with `op_valid` low, or with an operation code of 13 to 15, changes neither `res_q` nor `flags_q`, and leaves `res_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 4 | Operation selector, codes 0 to 12 |
| reg_a | input | 8 | First operand |
| reg_b | input | 8 | Second operand from the register file |
| imm | input | 8 | Immediate second operand |
| imm_sel | input | 1 | Use `imm` instead of `reg_b` |
| res_q | output | 8 | Last written result |
| res_we | output | 1 | Write-back strobe for `res_q` |
| flags_q | output | 6 | Status word {H,S,V,N,Z,C} |

## Verification
`res_q`, `res_we` and `flags_q` all become valid one clock edge after the cycle that offers the operation. The bench drives its inputs at the falling edge and waits for the next rising edge. It then compares the outputs at the following falling edge, before it offers anything else.

The expected status word is carried forward in the bench from its own integer arithmetic, so carry chains and the sticky zero bit are checked across consecutive operations. Idle cycles and unused codes are checked at the next falling edge to confirm that nothing moved.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_CPC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_COM  = 4'd9,
        OP_NEG  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } alu_op_e;

    localparam int NFLAGS = 6;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_N   = 2;
    localparam int FL_V   = 3;
    localparam int FL_S   = 4;
    localparam int FL_H   = 5;

    localparam logic [NFLAGS-1:0] MASK_ARITH = 6'b111111;
    localparam logic [NFLAGS-1:0] MASK_LOGIC = 6'b011110;
    localparam logic [NFLAGS-1:0] MASK_COMPL = 6'b011111;
    localparam logic [NFLAGS-1:0] MASK_NONE  = 6'b000000;

endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic              c_in,
    input  logic              z_in,
    output logic [W-1:0]      result,
    output logic [NFLAGS-1:0] flg_new,
    output logic              writes
);
    localparam int HALF = W / 2;

    logic [W-1:0]    x, y;
    logic            ci;
    logic            use_sub;
    logic [W:0]      add_full, sub_full;
    logic [HALF:0]   add_lo, sub_lo;
    logic [W-1:0]    r;
    logic            fc, fh, fv, fn, fz;

    // operand routing for the shared adder and subtractor
    always_comb begin
        x       = opnd_a;
        y       = opnd_b;
        ci      = 1'b0;
        use_sub = 1'b0;
        unique case (op)
            OP_ADC:                 ci = c_in;
            OP_SUB, OP_CMP:         use_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                use_sub = 1'b1;
                ci      = c_in;
            end
            OP_NEG: begin
                use_sub = 1'b1;
                x       = '0;
                y       = opnd_a;
            end
            OP_INC:                 y = W'(1);
            OP_DEC: begin
                use_sub = 1'b1;
                y       = W'(1);
            end
            default: ;
        endcase
    end

    assign add_full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    assign sub_full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, ci};
    assign add_lo   = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ci};
    assign sub_lo   = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, ci};

    always_comb begin
        r  = use_sub ? sub_full[W-1:0] : add_full[W-1:0];
        fc = use_sub ? sub_full[W] : add_full[W];
        fh = use_sub ? sub_lo[HALF] : add_lo[HALF];
        if (use_sub)
            fv = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
        else
            fv = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
        unique case (op)
            OP_AND: begin r = opnd_a & opnd_b; fv = 1'b0; end
            OP_OR:  begin r = opnd_a | opnd_b; fv = 1'b0; end
            OP_XOR: begin r = opnd_a ^ opnd_b; fv = 1'b0; end
            OP_COM: begin r = ~opnd_a; fv = 1'b0; fc = 1'b1; end
            default: ;
        endcase
        fn = r[W-1];
        if (op == OP_SBC || op == OP_CPC)
            fz = (r == '0) && z_in;
        else
            fz = (r == '0);
    end

    always_comb begin
        result         = r;
        flg_new        = '0;
        flg_new[FL_C]  = fc;
        flg_new[FL_Z]  = fz;
        flg_new[FL_N]  = fn;
        flg_new[FL_V]  = fv;
        flg_new[FL_S]  = fn ^ fv;
        flg_new[FL_H]  = fh;
        writes         = !(op == OP_CMP || op == OP_CPC ||
                           op == OP_RSV0 || op == OP_RSV1 || op == OP_RSV2);
    end

endmodule

// File: rtl/alu8_flagmask.sv
module alu8_flagmask
    import alu8_pkg::*;
(
    input  alu_op_e           op,
    output logic [NFLAGS-1:0] mask
);
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_CMP, OP_CPC, OP_NEG:         mask = MASK_ARITH;
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC:                 mask = MASK_LOGIC;
            OP_COM:                         mask = MASK_COMPL;
            default:                        mask = MASK_NONE;
        endcase
    end
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [W-1:0]      reg_a,
    input  logic [W-1:0]      reg_b,
    input  logic [W-1:0]      imm,
    input  logic              imm_sel,
    output logic [W-1:0]      res_q,
    output logic              res_we,
    output logic [NFLAGS-1:0] flags_q
);
    alu_op_e           op;
    logic [W-1:0]      opnd_b;
    logic [W-1:0]      core_res;
    logic [NFLAGS-1:0] core_flg;
    logic [NFLAGS-1:0] upd_mask;
    logic [NFLAGS-1:0] flags_d;
    logic              core_wr;

    assign op     = alu_op_e'(op_code);
    assign opnd_b = imm_sel ? imm : reg_b;

    alu8_core #(.W(W)) u_core (
        .op      (op),
        .opnd_a  (reg_a),
        .opnd_b  (opnd_b),
        .c_in    (flags_q[FL_C]),
        .z_in    (flags_q[FL_Z]),
        .result  (core_res),
        .flg_new (core_flg),
        .writes  (core_wr)
    );

    alu8_flagmask u_mask (
        .op   (op),
        .mask (upd_mask)
    );

    // per-bit merge of fresh and held status
    for (genvar i = 0; i < NFLAGS; i++) begin : g_merge
        assign flags_d[i] = (op_valid && upd_mask[i]) ? core_flg[i] : flags_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            res_we  <= 1'b0;
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
            res_we  <= op_valid && core_wr;
            if (op_valid && core_wr)
                res_q <= core_res;
        end
    end

    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd4 || op_code == 4'd5)) |=> (!res_we && $stable(res_q)));

    p_zero_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd3 || op_code == 4'd5) && !flags_q[FL_Z]) |=> !flags_q[FL_Z]);

    p_logic_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd6 && op_code <= 4'd8) |=>
        (flags_q[FL_C] == $past(flags_q[FL_C]) && flags_q[FL_H] == $past(flags_q[FL_H]) && !flags_q[FL_V]));

    p_com_sets_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9) |=> (flags_q[FL_C] && !flags_q[FL_V]));

    p_sign_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[FL_S] == (flags_q[FL_N] ^ flags_q[FL_V]));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code >= 4'd13) |=> ($stable(flags_q) && $stable(res_q) && !res_we));

endmodule

// File: tb/sim_alu8_status_unit.sv
module sim_alu8_status_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op_code;
    logic [7:0] reg_a, reg_b, imm;
    logic       imm_sel;
    logic [7:0] res_q;
    logic       res_we;
    logic [5:0] flags_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_res;
    logic [5:0] m_flg;

    always #4 clk = ~clk;

    alu8_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .imm_sel(imm_sel),
        .res_q(res_q), .res_we(res_we), .flags_q(flags_q)
    );

    function automatic string req_of(int op);
        case (op)
            0, 1:   return "R2";
            2, 3:   return "R3";
            4, 5:   return "R4";
            6, 7, 8: return "R6";
            9:      return "R7";
            10:     return "R8";
            11, 12: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] ar, logic aw, logic [5:0] af,
                         logic [7:0] er, logic ew, logic [5:0] ef);
        checks++;
        if (ar !== er || aw !== ew || af !== ef) begin
            failures++;
            $display("FAIL %s res=%h we=%b flags=%b expected res=%h we=%b flags=%b",
                     req, ar, aw, af, er, ew, ef);
        end
    endtask

    // expected behaviour from integer arithmetic
    task automatic run_op(int op, int a, int bv, int iv, bit sel, bit valid, string req);
        int b, c, s, sa, sb, r, lo;
        bit fc, fh, fv, fn, fz, wr;
        logic [5:0] nf;
        b  = sel ? iv : bv;
        c  = m_flg[0];
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        nf = m_flg;
        wr = 1'b0;
        if (valid && op <= 12) begin
            fc = m_flg[0]; fh = m_flg[5]; fv = 0;
            case (op)
                0, 1: begin
                    if (op == 0) c = 0;
                    s = a + b + c; r = s & 255; fc = s > 255;
                    lo = (a & 15) + (b & 15) + c; fh = lo > 15;
                    fv = (sa + sb + c > 127) || (sa + sb + c < -128);
                end
                2, 3, 4, 5: begin
                    if (op == 2 || op == 4) c = 0;
                    s = a - b - c; r = s & 255; fc = s < 0;
                    lo = (a & 15) - (b & 15) - c; fh = lo < 0;
                    fv = (sa - sb - c > 127) || (sa - sb - c < -128);
                end
                6: r = a & b;
                7: r = a | b;
                8: r = a ^ b;
                9: begin r = 255 - a; fc = 1; end
                10: begin
                    s = -a; r = s & 255; fc = a != 0;
                    fh = (a & 15) != 0; fv = (-sa > 127);
                end
                11: begin r = (a + 1) & 255; fv = (sa + 1 > 127); end
                default: begin r = (a + 255) & 255; fv = (sa - 1 < -128); end
            endcase
            fn = r > 127;
            fz = (r == 0);
            if (op == 3 || op == 5) fz = (r == 0) && m_flg[1];
            nf = {fh, fn ^ fv, fv, fn, fz, fc};
            wr = !(op == 4 || op == 5);
            if (wr) m_res = r[7:0];
        end
        m_flg = nf;
        @(negedge clk);
        op_valid = valid; op_code = op[3:0]; reg_a = a[7:0]; reg_b = bv[7:0];
        imm = iv[7:0]; imm_sel = sel;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check(req, res_q, res_we, flags_q, m_res, wr, m_flg);
        checks++;
        if (flags_q[4] !== (flags_q[2] ^ flags_q[3])) begin
            failures++;
            $display("FAIL R10 S=%b expected %b", flags_q[4], flags_q[2] ^ flags_q[3]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_valid = 0; op_code = 0; reg_a = 0; reg_b = 0; imm = 0; imm_sel = 0;
        m_res = 0; m_flg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", res_q, res_we, flags_q, 8'h00, 1'b0, 6'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1", res_q, res_we, flags_q, 8'h00, 1'b0, 6'b0);

        // sweep every code over every first operand
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 256; a++)
                run_op(op, a, (a * 37 + op * 11 + 5) & 255, 0, 1'b0, 1'b1, req_of(op));

        // second operand fully swept for the arithmetic codes
        for (int op = 0; op < 6; op++)
            for (int b = 0; b < 256; b++)
                run_op(op, (op * 53 + 128) & 255, b, 0, 1'b0, 1'b1, req_of(op));

        // immediate operand path
        for (int i = 0; i < 256; i++)
            run_op(i % 9, (i * 7) & 255, (~i) & 255, i, 1'b1, 1'b1, "R11");

        // chained compare: sticky zero across bytes
        run_op(2, 8'h10, 8'h10, 0, 1'b0, 1'b1, "R5");
        run_op(5, 8'h22, 8'h22, 0, 1'b0, 1'b1, "R5");
        run_op(5, 8'h23, 8'h22, 0, 1'b0, 1'b1, "R5");
        run_op(5, 8'h40, 8'h40, 0, 1'b0, 1'b1, "R5");
        run_op(3, 8'h00, 8'h00, 0, 1'b0, 1'b1, "R5");

        // overflow boundaries for increment and decrement
        run_op(11, 8'h7F, 0, 0, 1'b0, 1'b1, "R9");
        run_op(12, 8'h80, 0, 0, 1'b0, 1'b1, "R9");
        run_op(10, 8'h80, 0, 0, 1'b0, 1'b1, "R8");

        // idle cycles with busy inputs
        for (int i = 0; i < 32; i++)
            run_op(i % 13, (i * 29) & 255, i, i, i[0], 1'b0, "R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule